// File: doc/BRIEF.md
# Register Stack and Increment/Decrement Unit

This unit executes the one-byte opcodes that bump a 32-bit register up or down by one and that move a register to or from a word stack. It also executes the two register-direct forms of the 0xFF group opcode that increment or decrement. The unit owns the eight general registers and a small internal stack RAM. The RAM is indexed by byte address and holds one 32-bit word per four bytes, starting at a base address set by a parameter. Register 4 serves as the stack pointer.

Opcodes arrive one per clock with a valid strobe. The 0xFF form supplies its ModR/M byte on a second input in the same cycle. Increment and decrement finish at the edge that accepts them. Push and pop occupy a fixed two cycles, and during the second of these `busy` is high. A load port lets a neighbouring unit write a register, and a combinational read port exposes any register. An illegal stack access, or a 0xFF opcode that is not register-direct, sets a sticky error flag and changes nothing.

Top module: `reg_stack_unit`

## Requirements
- R1: Opcodes 0x40..0x47 add one to the register whose index is the low three opcode bits, wrapping modulo 2^32, at the accepting edge.
- R2: Opcodes 0x48..0x4F subtract one from the register whose index is the low three opcode bits, wrapping modulo 2^32, at the accepting edge.
- R3: Opcode 0xFF with ModR/M bits [7:6]=3 works on the register indexed by ModR/M bits [2:0]. ModR/M bits [5:3]=0 increment it and =1 decrement it, so 0xFF 0xC0 increments register 0 and 0xFF 0xC8 decrements it. Any other value of bits [5:3] leaves all state unchanged.
- R4: Opcodes 0x50..0x57 push register (opcode bits [2:0]). Register 4 drops by 4, and the pushed value is stored at the new register 4 address. Pushing register 4 stores its value from before the decrement.
- R5: Opcodes 0x58..0x5F pop into register (opcode bits [2:0]). The word is read at the current register 4 address, and register 4 then rises by 4. A pop into register 4 leaves it equal to the popped word.
- R6: A push or pop holds `busy` high for exactly the one cycle after its accepting edge, and completes at the end of that cycle. An opcode presented while `busy` is high is ignored. Increment and decrement never raise `busy`.
- R7: A push or pop whose byte address falls outside [STACK_BASE, STACK_BASE+4*STACK_WORDS) or is not a multiple of 4 sets `err` and changes no register or stack word. A 0xFF opcode with ModR/M bits [7:6] other than 3 also sets `err` and changes nothing. `err` clears only on reset.
- R8: Reset clears all eight registers, every stack word, `busy` and `err`.
- R9: `ld_en` writes `ld_data` into register `ld_sel` at the clock edge. An opcode update of the same register at the same edge takes precedence. `rd_data` always shows register `rd_sel`.
- R10: An accepted opcode outside the groups listed above changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode present this cycle |
| op_byte | input | 8 | Opcode |
| op_modrm | input | 8 | ModR/M byte, used with 0xFF |
| busy | output | 1 | Push or pop in its second cycle |
| err | output | 1 | Sticky error flag |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register to load |
| ld_data | input | DATA_W | Load value |
| rd_sel | input | 3 | Register to observe |
| rd_data | output | DATA_W | Value of the selected register |

## Verification
The bench builds the unit with STACK_BASE=0x40 and STACK_WORDS=16, so the stack window covers only 0x40 to 0x7F. With this window a few pushes or pops reach both ends. The last legal word at 0x7C, the underflow below 0x40 and the empty-side pop at 0x80 can therefore be exercised next to ordinary accesses such as a push from 0x64. A misaligned stack pointer can be tested in the same way.

// File: rtl/reg_stack_unit.sv
module reg_stack_unit #(
  parameter int DATA_W = 32,
  parameter int STACK_WORDS = 64,
  parameter logic [DATA_W-1:0] STACK_BASE = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_byte,
  input  logic [7:0]        op_modrm,
  output logic              busy,
  output logic              err,
  input  logic              ld_en,
  input  logic [2:0]        ld_sel,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [2:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SP = 4;
  localparam int STEP = DATA_W / 8;
  localparam int ALIGN_W = $clog2(STEP);
  localparam int IDX_W = (STACK_WORDS > 1) ? $clog2(STACK_WORDS) : 1;
  localparam logic [DATA_W:0] LIMIT = {1'b0, STACK_BASE} + (DATA_W+1)'(STEP * STACK_WORDS);

  logic [DATA_W-1:0] regs [8];
  logic [DATA_W-1:0] mem [STACK_WORDS];
  logic              pend_pop;
  logic [2:0]        pend_sel;

  wire accept  = op_valid && !busy;
  wire is_inc  = op_byte[7:3] == 5'b01000;
  wire is_dec  = op_byte[7:3] == 5'b01001;
  wire is_push = op_byte[7:3] == 5'b01010;
  wire is_pop  = op_byte[7:3] == 5'b01011;
  wire is_grp  = op_byte == 8'hFF;
  wire grp_direct = op_modrm[7:6] == 2'b11;
  wire grp_inc = is_grp && grp_direct && op_modrm[5:3] == 3'd0;
  wire grp_dec = is_grp && grp_direct && op_modrm[5:3] == 3'd1;

  wire       un_do  = accept && (is_inc || is_dec || grp_inc || grp_dec);
  wire       un_dn  = is_dec || grp_dec;
  wire [2:0] un_sel = is_grp ? op_modrm[2:0] : op_byte[2:0];
  wire       grp_fault = accept && is_grp && !grp_direct;

  wire [DATA_W-1:0] sp_val   = regs[SP];
  wire [DATA_W-1:0] acc_addr = pend_pop ? sp_val : sp_val - DATA_W'(STEP);
  wire [DATA_W-1:0] acc_off  = acc_addr - STACK_BASE;
  wire [IDX_W-1:0]  acc_idx  = IDX_W'(acc_off >> ALIGN_W);
  wire in_range = (acc_addr >= STACK_BASE) && ({1'b0, acc_addr} < LIMIT)
                  && (acc_addr[ALIGN_W-1:0] == '0);

  assign rd_data = regs[rd_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= '0;
      for (int j = 0; j < STACK_WORDS; j++) mem[j] <= '0;
      busy <= 1'b0;
      err <= 1'b0;
      pend_pop <= 1'b0;
      pend_sel <= '0;
    end else begin
      if (ld_en) regs[ld_sel] <= ld_data;
      if (un_do) regs[un_sel] <= un_dn ? regs[un_sel] - 1'b1 : regs[un_sel] + 1'b1;
      if (grp_fault) err <= 1'b1;
      if (accept && (is_push || is_pop)) begin
        busy <= 1'b1;
        pend_pop <= is_pop;
        pend_sel <= op_byte[2:0];
      end
      if (busy) begin
        busy <= 1'b0;
        if (!in_range) err <= 1'b1;
        else if (pend_pop) begin
          regs[SP] <= sp_val + DATA_W'(STEP);
          regs[pend_sel] <= mem[acc_idx];
        end else begin
          mem[acc_idx] <= regs[pend_sel];
          regs[SP] <= sp_val - DATA_W'(STEP);
        end
      end
    end
  end

  assert_inc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_inc) |=> regs[$past(op_byte[2:0])] == $past(regs[op_byte[2:0]]) + 1'b1);

  assert_dec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_dec) |=> regs[$past(op_byte[2:0])] == $past(regs[op_byte[2:0]]) - 1'b1);

  assert_push_sp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pend_pop && in_range) |=> regs[SP] == $past(regs[SP]) - DATA_W'(STEP));

  assert_pop_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pend_pop && in_range && pend_sel != 3'(SP)) |=> regs[SP] == $past(regs[SP]) + DATA_W'(STEP));

  assert_busy_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_fault_holds_sp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_range && !ld_en) |=> $stable(regs[SP]));
endmodule

// File: tb/reg_stack_unit_bench.sv
module reg_stack_unit_bench;
  localparam logic [31:0] BASE = 32'h40;
  localparam int WORDS = 16;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, ld_en = 0;
  logic [7:0] op_byte = 0, op_modrm = 0;
  logic [2:0] ld_sel = 0, rd_sel = 0;
  logic [31:0] ld_data = 0;
  logic busy, err;
  logic [31:0] rd_data;

  int compared = 0, mismatched = 0, cycles = 0;

  reg_stack_unit #(.DATA_W(32), .STACK_WORDS(WORDS), .STACK_BASE(BASE)) u_reg_stack_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte), .op_modrm(op_modrm),
    .busy(busy), .err(err), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .rd_sel(rd_sel), .rd_data(rd_data));

  always #10 clk = ~clk;

  logic [31:0] m_reg [8];
  logic [31:0] snap [8];
  logic [31:0] m_mem [logic [31:0]];
  logic m_busy, m_err, m_pop, acc, ready = 0;
  logic [2:0] m_sel;
  logic [31:0] a;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      m_mem.delete();
      m_busy = 0; m_err = 0; m_pop = 0; m_sel = 0; ready = 1;
    end else begin
      snap = m_reg;
      acc = op_valid && !m_busy;
      if (ld_en) m_reg[ld_sel] = ld_data;
      if (m_busy) begin
        m_busy = 0;
        a = m_pop ? snap[4] : snap[4] - 4;
        if (a < BASE || a >= BASE + 4*WORDS || a[1:0] != 0) m_err = 1;
        else if (m_pop) begin
          m_reg[4] = snap[4] + 4;
          m_reg[m_sel] = m_mem.exists(a) ? m_mem[a] : 32'h0;
        end else begin
          m_mem[a] = snap[m_sel];
          m_reg[4] = snap[4] - 4;
        end
      end else if (acc) begin
        case (op_byte) inside
          [8'h40:8'h47]: m_reg[op_byte[2:0]] = snap[op_byte[2:0]] + 1;
          [8'h48:8'h4F]: m_reg[op_byte[2:0]] = snap[op_byte[2:0]] - 1;
          [8'h50:8'h57]: begin m_busy = 1; m_pop = 0; m_sel = op_byte[2:0]; end
          [8'h58:8'h5F]: begin m_busy = 1; m_pop = 1; m_sel = op_byte[2:0]; end
          8'hFF: begin
            if (op_modrm[7:6] != 2'b11) m_err = 1;
            else if (op_modrm[5:3] == 0) m_reg[op_modrm[2:0]] = snap[op_modrm[2:0]] + 1;
            else if (op_modrm[5:3] == 1) m_reg[op_modrm[2:0]] = snap[op_modrm[2:0]] - 1;
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (ready && rst_n) begin
      compared += 3;
      if (busy !== m_busy) begin mismatched++; $display("FAIL R6 busy: got %0b expected %0b", busy, m_busy); end
      if (err !== m_err) begin mismatched++; $display("FAIL R7 err: got %0b expected %0b", err, m_err); end
      if (rd_data !== m_reg[rd_sel]) begin mismatched++;
        $display("FAIL R9 rd_data[%0d]: got %h expected %h", rd_sel, rd_data, m_reg[rd_sel]); end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin mismatched++; $display("FAIL %s: got %h expected %h", tag, act, exp); end
  endtask

  task automatic peek(logic [2:0] s, logic [31:0] exp, string tag);
    @(posedge clk); #1 rd_sel = s;
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  task automatic load(logic [2:0] s, logic [31:0] v);
    @(posedge clk); #1 ld_en = 1; ld_sel = s; ld_data = v;
    @(posedge clk); #1 ld_en = 0;
  endtask

  task automatic run_op(logic [7:0] op, logic [7:0] mr);
    @(posedge clk); #1 op_valid = 1; op_byte = op; op_modrm = mr;
    @(posedge clk); #1 op_valid = 0;
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R8 busy after reset", {31'b0, busy}, 0);
    chk("R8 err after reset", {31'b0, err}, 0);
    for (int i = 0; i < 8; i++) peek(3'(i), 0, "R8 register after reset");

    load(1, 32'h1f); run_op(8'h41, 0); peek(1, 32'h20, "R1 inc reg1");
    run_op(8'h49, 0); run_op(8'h49, 0); peek(1, 32'h1e, "R2 dec reg1 twice");
    load(7, 32'hFFFF_FFFF); run_op(8'h47, 0); peek(7, 0, "R1 wrap to zero");
    run_op(8'h4F, 0); peek(7, 32'hFFFF_FFFF, "R2 wrap below zero");

    load(0, 32'h20); run_op(8'hFF, 8'hC0); peek(0, 32'h21, "R3 FF C0 inc");
    run_op(8'hFF, 8'hC8); run_op(8'hFF, 8'hC8); peek(0, 32'h1f, "R3 FF C8 dec");
    run_op(8'hFF, 8'hD0); peek(0, 32'h1f, "R3 other sub-op no effect");
    run_op(8'h90, 0); peek(0, 32'h1f, "R10 unknown opcode no effect");

    load(4, 32'h64); load(3, 32'h0a);
    run_op(8'h53, 0); peek(4, 32'h60, "R4 push lowers sp");
    run_op(8'h5A, 0); peek(2, 32'h0a, "R5 pop value"); peek(4, 32'h64, "R5 pop raises sp");
    run_op(8'h54, 0); peek(4, 32'h60, "R4 push of sp");
    run_op(8'h59, 0); peek(1, 32'h64, "R4 pushed old sp");
    run_op(8'h53, 0); run_op(8'h5C, 0); peek(4, 32'h0a, "R5 pop into sp");

    load(0, 32'h5); load(4, 32'h64);
    @(posedge clk); #1 op_valid = 1; op_byte = 8'h53;
    @(posedge clk); #1 op_byte = 8'h40;
    chk("R6 busy after push accept", {31'b0, busy}, 1);
    @(posedge clk); #1 op_valid = 0;
    chk("R6 busy dropped", {31'b0, busy}, 0);
    peek(0, 32'h5, "R6 opcode during busy ignored");
    @(posedge clk); #1 op_valid = 1; op_byte = 8'h40;
    @(posedge clk); #1 op_valid = 0;
    chk("R6 inc keeps busy low", {31'b0, busy}, 0);

    @(posedge clk); #1 op_valid = 1; op_byte = 8'h41; ld_en = 1; ld_sel = 1; ld_data = 32'h999;
    @(posedge clk); #1 op_valid = 0; ld_en = 0;
    peek(1, 32'h65, "R9 opcode beats load");
    load(6, 32'h1234); peek(6, 32'h1234, "R9 load");

    load(4, 32'h80); load(5, 32'hABCD);
    run_op(8'h55, 0); peek(4, 32'h7C, "R4 push to top word");
    run_op(8'h5E, 0); peek(6, 32'hABCD, "R5 pop top word"); peek(4, 32'h80, "R5 sp at limit");
    chk("R7 no error yet", {31'b0, err}, 0);
    run_op(8'h5E, 0); peek(4, 32'h80, "R7 pop past limit suppressed");
    chk("R7 err set by range", {31'b0, err}, 1);
    load(4, 32'h40); run_op(8'h55, 0); peek(4, 32'h40, "R7 push underflow suppressed");
    load(4, 32'h62); run_op(8'h5E, 0); peek(6, 32'hABCD, "R7 misaligned pop suppressed");
    load(0, 32'h7); run_op(8'hFF, 8'h00); peek(0, 32'h7, "R7 indirect FF suppressed");
    chk("R7 err sticky", {31'b0, err}, 1);

    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R8 err cleared by reset", {31'b0, err}, 0);
    peek(6, 0, "R8 reg cleared by reset");
    load(4, 32'h7C); run_op(8'h58, 0); peek(0, 0, "R8 stack word cleared");

    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule